// File: doc/BRIEF.md
# Mode-Configurable PHY Status LED Driver

This block drives the three status LED pins of one 10/100 Ethernet port: a link pin, a speed pin and an auxiliary pin. The auxiliary pin shows activity, collision or duplex, depending on the mode. Its inputs are the port's live status: link up, 100 Mb/s speed, transmit active, receive active, collision and full duplex. It also takes three configuration sources. The first is a strap that picks between two board-level modes. The second is a register bit that forces a third, programmable mode. The third is a register bit that, in the programmable mode only, shows duplex instead of collision on the auxiliary pin.

Short activity and collision events are stretched to a visible minimum on-time. A prescaler divides the core clock into a slow tick, and every stretch and blink window counts in ticks. In the two richer modes the link pin blinks while stretched activity is present. After activity stops, the blinker finishes the phase it is in before returning to steady light.

Each pin has its own strap level. The block captures these levels while reset is asserted and uses them to set the pin's drive polarity. A pin strapped high is lit by driving it low. A pin strapped low is lit by driving it high.

The design has two small state machines. The stretcher, instantiated once for activity and once for collision, has two states. STR_IDLE goes to STR_HOLD on an event. STR_HOLD goes back to STR_IDLE once a full window of ticks passes with no event, and any new event restarts the window. The blinker has three states. BLK_STEADY goes to BLK_DARK when stretched activity is present. BLK_DARK goes to BLK_LIT at the end of its phase if activity remains, or to BLK_STEADY if not. BLK_LIT goes to BLK_DARK at the end of its phase if activity remains, or to BLK_STEADY if not.

Top module: `phy_led_driver`

## Requirements
- R1: While rst_n is low, all three pins of led_pin are driven low.
- R2: The block samples strap_pin_lvl and strap_mode_sel on every clock edge while rst_n is low and holds the last sampled values until the next reset. Later changes to those inputs have no effect. The pin for bit i is driven as its lit value XOR the held strap_pin_lvl[i], so a pin strapped high is active-low.
- R3: led_pin[1] is the speed pin. One clock after speed_100 is sampled, it is lit if speed_100 is 1 and dark if it is 0, in every mode.
- R4: In mode 1 (cfg_mode3=0, held strap_mode_sel=0), led_pin[0] is lit one clock after link_up is sampled high and is dark otherwise.
- R5: In mode 1, led_pin[2] shows stretched activity, where activity is tx_active OR rx_active.
- R6: A stretched indicator turns on in the clock after its event is sampled. It stays on while the event persists. It turns off only after STRETCH_TICKS ticks have passed since the event was last seen. The indicator output reaches the pin one clock later.
- R7: A tick occurs once every PRESCALE clocks, counted from reset release.
- R8: In modes 2 and 3, led_pin[0] is lit when link_up is high and the blinker is not dark. With stretched activity present, the blinker alternates dark and lit phases of BLINK_HALF_TICKS ticks each, starting with dark. When activity is absent at the end of a phase, the blinker returns to steady light.
- R9: In mode 2 (cfg_mode3=0, held strap_mode_sel=1), led_pin[2] shows stretched collision.
- R10: cfg_mode3=1 selects mode 3 whatever the strap, and takes effect from the next clock. In mode 3, led_pin[2] shows full_duplex when cfg_aux_duplex=1 and stretched collision when cfg_aux_duplex=0.
- R11: Outside mode 3, cfg_aux_duplex has no effect on any pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock (nominally 25 MHz) |
| rst_n | input | 1 | Asynchronous active-low reset; straps are sampled while it is low |
| link_up | input | 1 | Link is good |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| tx_active | input | 1 | Transmitter busy |
| rx_active | input | 1 | Receiver busy |
| collision | input | 1 | Collision detected |
| full_duplex | input | 1 | Link runs full duplex |
| strap_mode_sel | input | 1 | Board strap: 0 = mode 1, 1 = mode 2 |
| strap_pin_lvl | input | 3 | Level on each LED pin during strap sampling (bit 0 link, 1 speed, 2 auxiliary) |
| cfg_mode3 | input | 1 | Register bit forcing mode 3 |
| cfg_aux_duplex | input | 1 | Register bit: mode 3 auxiliary pin shows duplex (1) or collision (0) |
| led_pin | output | 3 | Polarity-adjusted LED drive (bit 0 link, 1 speed, 2 auxiliary) |

## Verification
The assertions assume that status inputs change only between clock edges and are stable at each sampling edge. They also assume the strap inputs matter only while rst_n is low. The stimulus drives every input on the falling clock edge, so each value is settled a half period before it is sampled. Strap values are set before reset is released and are then deliberately inverted, which exercises the hold behaviour. Activity and collision follow bursty pseudo-random patterns with long quiet gaps, so that both stretch expiry and the return of the blinker to steady light occur many times in each mode.

// File: rtl/led_drv_pkg.sv
package led_drv_pkg;

    localparam int LED_PINS  = 3;
    localparam int PIN_LINK  = 0;
    localparam int PIN_SPEED = 1;
    localparam int PIN_AUX   = 2;

    typedef enum logic [1:0] {
        LEDM_LINK_ACT  = 2'd1,
        LEDM_BLINK_COL = 2'd2,
        LEDM_PROG      = 2'd3
    } led_mode_e;

    typedef enum logic {
        STR_IDLE,
        STR_HOLD
    } str_state_e;

    typedef enum logic [1:0] {
        BLK_STEADY,
        BLK_DARK,
        BLK_LIT
    } blk_state_e;

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int PRESCALE = 25000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (PRESCALE > 1) begin : g_spacing_chk
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick); // R7
        end
    endgenerate

endmodule

// File: rtl/led_stretch.sv
module led_stretch
    import led_drv_pkg::*;
#(
    parameter int HOLD_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic evt,
    output logic shown
);
    localparam int CW = (HOLD_TICKS > 1) ? $clog2(HOLD_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLD_TICKS - 1);

    str_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= STR_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            STR_IDLE: begin
                if (evt) begin
                    state_d = STR_HOLD;
                    cnt_d   = '0;
                end
            end
            STR_HOLD: begin
                if (evt) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == LAST) begin
                        state_d = STR_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = STR_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            STR_HOLD: shown = 1'b1;
            default:  shown = 1'b0;
        endcase
    end

    AST_EVT_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> shown); // R6
    AST_HOLD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shown) |-> ($past(tick) && !$past(evt))); // R6

endmodule

// File: rtl/led_blink.sv
module led_blink
    import led_drv_pkg::*;
#(
    parameter int HALF_TICKS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic act,
    output logic lit
);
    localparam int CW = (HALF_TICKS > 1) ? $clog2(HALF_TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_TICKS - 1);

    blk_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic phase_end;

    assign phase_end = tick && (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BLK_STEADY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            BLK_STEADY: begin
                if (act) begin
                    state_d = BLK_DARK;
                    cnt_d   = '0;
                end
            end
            BLK_DARK: begin
                if (phase_end) begin
                    state_d = act ? BLK_LIT : BLK_STEADY;
                    cnt_d   = '0;
                end else if (tick) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            BLK_LIT: begin
                if (phase_end) begin
                    state_d = act ? BLK_DARK : BLK_STEADY;
                    cnt_d   = '0;
                end else if (tick) begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            default: begin
                state_d = BLK_STEADY;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            BLK_DARK: lit = 1'b0;
            default:  lit = 1'b1;
        endcase
    end

    AST_DARK_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == BLK_DARK) |-> $past(act)); // R8
    AST_IDLE_STAYS_LIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!act && lit && state_q == BLK_STEADY) |=> lit); // R8

endmodule

// File: rtl/phy_led_driver.sv
module phy_led_driver
    import led_drv_pkg::*;
#(
    parameter int PRESCALE         = 25000,
    parameter int STRETCH_TICKS    = 50,
    parameter int BLINK_HALF_TICKS = 50
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                link_up,
    input  logic                speed_100,
    input  logic                tx_active,
    input  logic                rx_active,
    input  logic                collision,
    input  logic                full_duplex,
    input  logic                strap_mode_sel,
    input  logic [LED_PINS-1:0] strap_pin_lvl,
    input  logic                cfg_mode3,
    input  logic                cfg_aux_duplex,
    output logic [LED_PINS-1:0] led_pin
);
    localparam int NUM_EVT = 2;
    localparam int EVT_ACT = 0;
    localparam int EVT_COL = 1;

    logic                tick;
    logic [NUM_EVT-1:0]  evt_raw;
    logic [NUM_EVT-1:0]  evt_shown;
    logic                blink_lit;
    logic [LED_PINS-1:0] strap_lvl_q;
    logic                strap_mode_q;
    led_mode_e           mode;
    logic [LED_PINS-1:0] lit_vec;

    // straps follow their inputs during reset and freeze at release
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strap_lvl_q  <= strap_pin_lvl;
            strap_mode_q <= strap_mode_sel;
        end
    end

    led_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    assign evt_raw[EVT_ACT] = tx_active | rx_active;
    assign evt_raw[EVT_COL] = collision;

    generate
        for (genvar e = 0; e < NUM_EVT; e++) begin : g_stretch
            led_stretch #(.HOLD_TICKS(STRETCH_TICKS)) u_str (
                .clk   (clk),
                .rst_n (rst_n),
                .tick  (tick),
                .evt   (evt_raw[e]),
                .shown (evt_shown[e])
            );
        end
    endgenerate

    led_blink #(.HALF_TICKS(BLINK_HALF_TICKS)) u_blink (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .act   (evt_shown[EVT_ACT]),
        .lit   (blink_lit)
    );

    always_comb begin
        if (cfg_mode3)         mode = LEDM_PROG;
        else if (strap_mode_q) mode = LEDM_BLINK_COL;
        else                   mode = LEDM_LINK_ACT;
    end

    always_comb begin
        lit_vec[PIN_SPEED] = speed_100;
        unique case (mode)
            LEDM_LINK_ACT: begin
                lit_vec[PIN_LINK] = link_up;
                lit_vec[PIN_AUX]  = evt_shown[EVT_ACT];
            end
            LEDM_BLINK_COL: begin
                lit_vec[PIN_LINK] = link_up & blink_lit;
                lit_vec[PIN_AUX]  = evt_shown[EVT_COL];
            end
            LEDM_PROG: begin
                lit_vec[PIN_LINK] = link_up & blink_lit;
                lit_vec[PIN_AUX]  = cfg_aux_duplex ? full_duplex : evt_shown[EVT_COL];
            end
            default: begin
                lit_vec[PIN_LINK] = 1'b0;
                lit_vec[PIN_AUX]  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_pin <= '0;
        end else begin
            led_pin <= lit_vec ^ strap_lvl_q;
        end
    end

    AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(strap_lvl_q) && $stable(strap_mode_q)); // R2
    AST_SPEED_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (led_pin[PIN_SPEED] == ($past(speed_100) ^ strap_lvl_q[PIN_SPEED]))); // R3
    AST_MODE1_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LEDM_LINK_ACT) |=> (led_pin[PIN_LINK] == ($past(link_up) ^ strap_lvl_q[PIN_LINK]))); // R4
    AST_DUPLEX_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode3 && cfg_aux_duplex) |=> (led_pin[PIN_AUX] == ($past(full_duplex) ^ strap_lvl_q[PIN_AUX]))); // R10

endmodule

// File: tb/phy_led_driver_tb_top.sv
module phy_led_driver_tb_top;
    localparam int P = 4;
    localparam int S = 3;
    localparam int B = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_up = 0, speed_100 = 0, tx_active = 0, rx_active = 0;
    logic       collision = 0, full_duplex = 0, strap_mode_sel = 0;
    logic [2:0] strap_pin_lvl = 3'b000;
    logic       cfg_mode3 = 0, cfg_aux_duplex = 0;
    logic [2:0] led_pin;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference model state
    logic [2:0] exp_pin = 3'b000;
    logic [2:0] m_lvl = 3'b000;
    logic       m_smode = 1'b0;
    int presc = 0;
    int a_on = 0, a_cnt = 0, c_on = 0, c_cnt = 0;
    int b_ph = 0, b_cnt = 0;   // 0 steady, 1 dark, 2 lit

    always #2.5 clk = ~clk;

    phy_led_driver #(.PRESCALE(P), .STRETCH_TICKS(S), .BLINK_HALF_TICKS(B)) dut_i (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .speed_100(speed_100),
        .tx_active(tx_active), .rx_active(rx_active), .collision(collision),
        .full_duplex(full_duplex), .strap_mode_sel(strap_mode_sel),
        .strap_pin_lvl(strap_pin_lvl), .cfg_mode3(cfg_mode3),
        .cfg_aux_duplex(cfg_aux_duplex), .led_pin(led_pin)
    );

    function automatic int cur_mode();
        return cfg_mode3 ? 3 : (m_smode ? 2 : 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_lvl = strap_pin_lvl; m_smode = strap_mode_sel;
            exp_pin = 3'b000; presc = 0;
            a_on = 0; a_cnt = 0; c_on = 0; c_cnt = 0; b_ph = 0; b_cnt = 0;
        end else begin
            automatic bit tk = (presc == P - 1);
            automatic int md = cur_mode();
            automatic bit l0, l2;
            automatic bit aevt = tx_active | rx_active;
            l0 = (md == 1) ? link_up : (link_up && (b_ph != 1));
            if (md == 1)      l2 = (a_on != 0);
            else if (md == 2) l2 = (c_on != 0);
            else              l2 = cfg_aux_duplex ? full_duplex : (c_on != 0);
            exp_pin = {l2, speed_100, l0} ^ m_lvl;
            // blinker uses the stretched activity before this edge
            if (b_ph == 0) begin
                if (a_on != 0) begin b_ph = 1; b_cnt = 0; end
            end else if (tk) begin
                if (b_cnt == B - 1) begin
                    b_cnt = 0;
                    if (a_on == 0) b_ph = 0;
                    else b_ph = (b_ph == 1) ? 2 : 1;
                end else b_cnt++;
            end
            // stretchers
            if (a_on == 0) begin if (aevt) begin a_on = 1; a_cnt = 0; end end
            else if (aevt) a_cnt = 0;
            else if (tk) begin if (a_cnt == S - 1) a_on = 0; else a_cnt++; end
            if (c_on == 0) begin if (collision) begin c_on = 1; c_cnt = 0; end end
            else if (collision) c_cnt = 0;
            else if (tk) begin if (c_cnt == S - 1) c_on = 0; else c_cnt++; end
            presc = tk ? 0 : presc + 1;
        end
    end

    function automatic string pin_tag(int i);
        int md = cur_mode();
        if (!rst_n) return "R1";
        if (i == 1) return "R3 (R2 polarity)";
        if (i == 0) return (md == 1) ? "R4 (R2 polarity)" : "R8 (R7 tick, R6 stretch, R2 polarity)";
        if (md == 1) return "R5 (R6 stretch, R7 tick, R2 polarity)";
        if (md == 2) return cfg_aux_duplex ? "R11 (R9 collision, R6)" : "R9 (R6 stretch, R2 polarity)";
        return "R10 (R6 stretch, R2 polarity)";
    endfunction

    task automatic step();
        @(negedge clk);
        cycles++;
        for (int i = 0; i < 3; i++) begin
            checks++;
            if (led_pin[i] !== exp_pin[i]) begin
                errors++;
                $display("FAIL %s pin%0d at cycle %0d: actual=%b expected=%b",
                         pin_tag(i), i, cycles, led_pin[i], exp_pin[i]);
            end
        end
    endtask

    task automatic run_scenario(input logic [2:0] lvl, input logic smode,
                                input logic m3, input logic dup, input int n, input bit live);
        rst_n = 1'b0;
        strap_pin_lvl = lvl; strap_mode_sel = smode;
        cfg_mode3 = m3; cfg_aux_duplex = dup;
        repeat (3) step();   // R1 checked during reset
        rst_n = 1'b1;
        step();
        strap_pin_lvl = ~lvl;          // R2: must be ignored now
        strap_mode_sel = ~smode;
        for (int k = 0; k < n; k++) begin
            if ($urandom_range(0, 15) == 0) tx_active = ~tx_active;
            if ($urandom_range(0, 23) == 0) rx_active = ~rx_active;
            if ($urandom_range(0, 19) == 0) collision = ~collision;
            if ($urandom_range(0, 39) == 0) link_up = ~link_up;
            if ($urandom_range(0, 29) == 0) speed_100 = ~speed_100;
            if ($urandom_range(0, 25) == 0) full_duplex = ~full_duplex;
            if ((k % 120) > 70) begin   // quiet gap: stretch expiry, blink stops
                tx_active = 0; rx_active = 0; collision = 0;
            end
            if (live && (k % 97) == 0) cfg_mode3 = ~cfg_mode3;       // R10 live select
            if (live && (k % 61) == 0) cfg_aux_duplex = ~cfg_aux_duplex;
            step();
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        step();
        run_scenario(3'b000, 1'b0, 1'b0, 1'b0, 600, 0);   // mode 1, active-high
        run_scenario(3'b111, 1'b0, 1'b0, 1'b1, 600, 0);   // mode 1, active-low, R11
        run_scenario(3'b101, 1'b1, 1'b0, 1'b0, 600, 0);   // mode 2
        run_scenario(3'b010, 1'b1, 1'b0, 1'b1, 600, 0);   // mode 2, R11
        run_scenario(3'b000, 1'b0, 1'b1, 1'b0, 600, 0);   // mode 3 collision
        run_scenario(3'b110, 1'b0, 1'b1, 1'b1, 600, 0);   // mode 3 duplex
        run_scenario(3'b011, 1'b1, 1'b1, 1'b1, 600, 0);   // mode 3 over strap mode 2
        run_scenario(3'b100, 1'b1, 1'b0, 1'b0, 1200, 1);  // live register changes
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog (all requirements): actual=hung expected=completed");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule